// File: doc/BRIEF.md
# Inter-Processor Mailbox Channel Bank

A bank of identical message channels that two or more processors share over a simple 32-bit register bus. Each channel sits in its own 64-byte window and holds a source owner, a destination interrupt selection, an interrupt mask, a pending set and a small array of message words. Register writes are blocked until a global lock register receives the unlock key.

A sender claims an idle channel by writing its own one-hot interrupt bit as the source. It reads that bit back to confirm the claim. It then programs the destination bits and the mask and fills the message words. Writing its own bit to the send register raises the destination interrupt and moves the channel to busy. The channel acknowledges in one of two ways. In automatic mode this happens after a fixed delay. In manual mode it happens once the receiver has cleared every pending destination bit. An acknowledge interrupt then appears on the sender's line until the sender clears it. This returns the channel to ready, and the sender may send again or release the channel.

Top module: `mbox_bank`

## Requirements
- R1: After reset every channel reads idle (status word 0x10), every mask reads all ones, source reads 0, and the lock register at 0xA00 reads 1.
- R2: Writing 0x1ACCE551 to 0xA00 unlocks the register file, and 0xA00 then reads 0. Writing any other value there locks it again, and it reads 1.
- R3: While locked, writes to any channel register or message word leave it unchanged.
- R4: Channel n occupies the window from n×0x40, and its source register is at offset 0x00. A one-hot write there while the channel is idle stores the bit, and the status word at 0x10 then reads ready (bit 5). Writes that are not one-hot, and writes to a channel that is not idle, are ignored.
- R5: Writing 0 to the source register of a ready channel clears the source and returns the channel to idle.
- R6: The send register is at 0x1C. In the ready state, writing exactly the source bit there ORs the destination bits (0x04) into the pending set and makes the channel busy (status bit 6). Any other value is ignored.
- R7: The word at 0x0C reads pending AND NOT mask, where the mask at 0x14 uses 1 for masked. Each such bit drives its interrupt line high one cycle after the pending bit is set. Masked bits keep their lines low.
- R8: A write to the clear register at 0x08 clears the pending bits that are set in the written value. The matching interrupt lines drop one cycle later.
- R9: Writing bit 0 of the status word (0x10) selects automatic acknowledge. In that mode a busy channel enters acknowledge (bit 7) ACK_DELAY cycles after the send write. The sender's interrupt line rises one cycle after that.
- R10: With bit 0 clear, a busy channel stays busy while any pending bit remains. It enters acknowledge on the cycle after the last pending bit is cleared, and the acknowledge interrupt follows.
- R11: In acknowledge, writing a value that contains the source bit to 0x18 returns the channel to ready. The acknowledge interrupt then drops.
- R12: Message word i of channel n sits at n×0x40 + 0x20 + 4×i. Each word reads back what was last written to it, independently of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe; data valid the next cycle |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 32 | Interrupt lines, OR of all channels' destination and acknowledge requests |

## Verification
The checks assume that a read strobe and a write strobe never fall in the same cycle. They also assume every address is word aligned and that reset is held for at least one clock edge. The stimulus drives one strobe at a time, each for exactly one cycle and followed by an idle cycle. It uses only aligned addresses. The sender bit it uses is kept apart from the destination bits, so that the acknowledge and destination interrupts can be observed on separate lines.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int BUS_W = 32;
  localparam int WIN_AW = 6;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_READY = 2'd1,
    CH_BUSY  = 2'd2,
    CH_ACK   = 2'd3
  } ch_state_e;

  localparam logic [2:0] REG_SRC   = 3'd0;
  localparam logic [2:0] REG_DST   = 3'd1;
  localparam logic [2:0] REG_DCLR  = 3'd2;
  localparam logic [2:0] REG_DSTAT = 3'd3;
  localparam logic [2:0] REG_MODE  = 3'd4;
  localparam logic [2:0] REG_MASK  = 3'd5;
  localparam logic [2:0] REG_ICLR  = 3'd6;
  localparam logic [2:0] REG_SEND  = 3'd7;

  localparam int MODE_AUTO  = 0;
  localparam int MODE_IDLE  = 4;
  localparam int MODE_READY = 5;
  localparam int MODE_BUSY  = 6;
  localparam int MODE_ACK   = 7;

  localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int NUM_CH = 32,
  parameter int DATA_WORDS = 8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 'hA00,
  localparam int CH_AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int WORD_AW = $clog2(DATA_WORDS)
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               is_lock,
  output logic               is_chan,
  output logic               is_data,
  output logic [CH_AW-1:0]   ch_idx,
  output logic [2:0]         reg_sel,
  output logic [WORD_AW-1:0] word_idx
);
  localparam logic [ADDR_W-1:0] CH_LIMIT = ADDR_W'(NUM_CH * (2 ** WIN_AW));

  always_comb begin
    is_lock  = (addr == LOCK_ADDR);
    is_chan  = (addr < CH_LIMIT) && (addr[1:0] == 2'b00);
    is_data  = addr[5] && ({29'b0, addr[4:2]} < 32'(DATA_WORDS));
    ch_idx   = addr[CH_AW+WIN_AW-1:WIN_AW];
    reg_sel  = addr[4:2];
    word_idx = addr[WORD_AW+1:2];
  end
endmodule

// File: rtl/mbox_lock.sv
module mbox_lock
  import mbox_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wdata,
  output logic             unlocked
);
  always_ff @(posedge clk) begin
    if (rst) unlocked <= 1'b0;
    else if (wr_en) unlocked <= (wdata == UNLOCK_KEY);
  end

  // R2: a non-key write always leaves the file locked
  p_relock_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata != UNLOCK_KEY) |=> !unlocked);
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan
  import mbox_pkg::*;
#(
  parameter int IRQ_W = 32,
  parameter int ACK_DELAY = 4,
  localparam int CNT_W = $clog2(ACK_DELAY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [2:0]       reg_sel,
  input  logic [BUS_W-1:0] wdata,
  output logic [IRQ_W-1:0] src_o,
  output logic [IRQ_W-1:0] dst_o,
  output logic [IRQ_W-1:0] mask_o,
  output logic [IRQ_W-1:0] pend_o,
  output logic [BUS_W-1:0] mode_o,
  output logic [IRQ_W-1:0] irq_o
);
  ch_state_e        state;
  logic             auto_ack;
  logic [CNT_W-1:0] cnt;
  logic [IRQ_W-1:0] wbits;
  logic             one_hot, claim_ok, release_ok, send_ok, iclr_ok;

  assign wbits = wdata[IRQ_W-1:0];

  always_comb begin
    one_hot    = (wbits != '0) && ((wbits & (wbits - 1'b1)) == '0);
    claim_ok   = wr_en && reg_sel == REG_SRC && state == CH_IDLE && one_hot;
    release_ok = wr_en && reg_sel == REG_SRC && state == CH_READY && wbits == '0;
    send_ok    = wr_en && reg_sel == REG_SEND && state == CH_READY && wbits == src_o;
    iclr_ok    = wr_en && reg_sel == REG_ICLR && state == CH_ACK && (wbits & src_o) != '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CH_IDLE;
      src_o    <= '0;
      dst_o    <= '0;
      mask_o   <= '1;
      pend_o   <= '0;
      auto_ack <= 1'b0;
      cnt      <= '0;
    end else begin
      if (wr_en) begin
        case (reg_sel)
          REG_DST:  dst_o    <= wbits;
          REG_MASK: mask_o   <= wbits;
          REG_MODE: auto_ack <= wdata[MODE_AUTO];
          default: ;
        endcase
      end
      if (send_ok) pend_o <= pend_o | dst_o;
      else if (wr_en && reg_sel == REG_DCLR) pend_o <= pend_o & ~wbits;
      if (claim_ok) src_o <= wbits;
      else if (release_ok) src_o <= '0;
      case (state)
        CH_IDLE: if (claim_ok) state <= CH_READY;
        CH_READY: begin
          if (release_ok) state <= CH_IDLE;
          else if (send_ok) begin
            state <= CH_BUSY;
            cnt   <= CNT_W'(ACK_DELAY - 1);
          end
        end
        CH_BUSY: begin
          if (auto_ack) begin
            if (cnt == '0) state <= CH_ACK;
            else cnt <= cnt - 1'b1;
          end else if (pend_o == '0) begin
            state <= CH_ACK;
          end
        end
        CH_ACK: if (iclr_ok) state <= CH_READY;
        default: state <= CH_IDLE;
      endcase
    end
  end

  always_comb begin
    mode_o             = '0;
    mode_o[MODE_AUTO]  = auto_ack;
    mode_o[MODE_IDLE]  = (state == CH_IDLE);
    mode_o[MODE_READY] = (state == CH_READY);
    mode_o[MODE_BUSY]  = (state == CH_BUSY);
    mode_o[MODE_ACK]   = (state == CH_ACK);
    irq_o = (pend_o & ~mask_o) | ((state == CH_ACK) ? src_o : '0);
  end

  // R4: a successful claim is visible on readback the next cycle
  p_claim_readback_r4: assert property (@(posedge clk) disable iff (rst)
    claim_ok |=> (src_o == $past(wbits)) && state == CH_READY);
  // R6: an accepted send always leaves the channel busy
  p_send_busy_r6: assert property (@(posedge clk) disable iff (rst)
    send_ok |=> state == CH_BUSY);
  // R9: acknowledge is only ever entered from busy
  p_ack_from_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (state == CH_ACK && $past(state) != CH_ACK) |-> $past(state) == CH_BUSY);
  // R9: the delay counter stays inside its window
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
    (state == CH_BUSY && auto_ack) |-> cnt < CNT_W'(ACK_DELAY));
  // R11: clearing the acknowledge returns to ready
  p_iclr_ready_r11: assert property (@(posedge clk) disable iff (rst)
    iclr_ok |=> state == CH_READY);
endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int IRQ_W = 32,
  parameter int DATA_WORDS = 8,
  parameter int ADDR_W = 12,
  parameter int ACK_DELAY = 4,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 'hA00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic [IRQ_W-1:0]  irq_o
);
  localparam int CH_AW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int WORD_AW = $clog2(DATA_WORDS);
  localparam int MEM_AW = CH_AW + WORD_AW;
  localparam int MEM_DEPTH = 2 ** MEM_AW;

  logic               is_lock, is_chan, is_data, unlocked, ch_wr;
  logic [CH_AW-1:0]   ch_idx;
  logic [2:0]         reg_sel;
  logic [WORD_AW-1:0] word_idx;
  logic [MEM_AW-1:0]  mem_addr;

  logic [IRQ_W-1:0] src_a  [NUM_CH];
  logic [IRQ_W-1:0] dst_a  [NUM_CH];
  logic [IRQ_W-1:0] mask_a [NUM_CH];
  logic [IRQ_W-1:0] pend_a [NUM_CH];
  logic [BUS_W-1:0] mode_a [NUM_CH];
  logic [IRQ_W-1:0] irq_a  [NUM_CH];
  logic [NUM_CH*IRQ_W-1:0] src_flat;

  logic [BUS_W-1:0] mem [MEM_DEPTH];
  logic [BUS_W-1:0] mem_q, reg_q, rd_val;
  logic             sel_mem_q;
  logic [IRQ_W-1:0] irq_d;

  mbox_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .DATA_WORDS(DATA_WORDS), .LOCK_ADDR(LOCK_ADDR)
  ) decode_i (
    .addr(bus_addr), .is_lock(is_lock), .is_chan(is_chan), .is_data(is_data),
    .ch_idx(ch_idx), .reg_sel(reg_sel), .word_idx(word_idx)
  );

  mbox_lock lock_i (
    .clk(clk), .rst(rst), .wr_en(bus_wr && is_lock), .wdata(bus_wdata), .unlocked(unlocked)
  );

  assign ch_wr    = bus_wr && unlocked && is_chan && !is_data;
  assign mem_addr = {ch_idx, word_idx};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    mbox_chan #(.IRQ_W(IRQ_W), .ACK_DELAY(ACK_DELAY)) chan_i (
      .clk(clk), .rst(rst),
      .wr_en(ch_wr && ch_idx == CH_AW'(g)),
      .reg_sel(reg_sel), .wdata(bus_wdata),
      .src_o(src_a[g]), .dst_o(dst_a[g]), .mask_o(mask_a[g]),
      .pend_o(pend_a[g]), .mode_o(mode_a[g]), .irq_o(irq_a[g])
    );
    assign src_flat[g*IRQ_W +: IRQ_W] = src_a[g];
  end

  // message words: single write port, registered read, no reset
  always_ff @(posedge clk) begin
    if (bus_wr && unlocked && is_chan && is_data) mem[mem_addr] <= bus_wdata;
    mem_q <= mem[mem_addr];
  end

  always_comb begin
    rd_val = '0;
    if (is_lock) begin
      rd_val = {31'b0, !unlocked};
    end else if (is_chan && !is_data) begin
      case (reg_sel)
        REG_SRC:   rd_val = BUS_W'(src_a[ch_idx]);
        REG_DST:   rd_val = BUS_W'(dst_a[ch_idx]);
        REG_DSTAT: rd_val = BUS_W'(pend_a[ch_idx] & ~mask_a[ch_idx]);
        REG_MODE:  rd_val = mode_a[ch_idx];
        REG_MASK:  rd_val = BUS_W'(mask_a[ch_idx]);
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q     <= '0;
      sel_mem_q <= 1'b0;
    end else if (bus_rd) begin
      reg_q     <= rd_val;
      sel_mem_q <= is_chan && is_data;
    end
  end

  assign bus_rdata = sel_mem_q ? mem_q : reg_q;

  always_comb begin
    irq_d = '0;
    for (int i = 0; i < NUM_CH; i++) irq_d = irq_d | irq_a[i];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else irq_o <= irq_d;
  end

  // R3: no channel ownership changes while the file is locked
  p_locked_src_r3: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && bus_wr) |=> $stable(src_flat));
endmodule

// File: tb/mbox_bank_tb.sv
`timescale 1ns/1ps
module mbox_bank_tb_top;
  localparam int D = 4;
  localparam logic [11:0] C3 = 12'h0C0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mbox_bank #(.ACK_DELAY(D)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic        is_rd;
    logic [11:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'hA00, 32'h1},          // R1 locked after reset
    '{1'b1, 12'h0D0, 32'h10},         // R1 idle
    '{1'b1, 12'h0D4, 32'hFFFF_FFFF},  // R1 mask set
    '{1'b0, 12'h0C0, 32'h4},          // R3 claim while locked
    '{1'b1, 12'h0C0, 32'h0},          // R3 ignored
    '{1'b0, 12'hA00, 32'h1ACC_E551},  // R2 unlock
    '{1'b1, 12'hA00, 32'h0},          // R2
    '{1'b0, 12'h0C0, 32'h6},          // R4 not one-hot
    '{1'b1, 12'h0C0, 32'h0},          // R4
    '{1'b0, 12'h0C0, 32'h4},          // R4 claim
    '{1'b1, 12'h0C0, 32'h4},          // R4 readback
    '{1'b1, 12'h0D0, 32'h20},         // R4 ready
    '{1'b0, 12'h0C0, 32'h8},          // R4 claim while not idle
    '{1'b1, 12'h0C0, 32'h4},          // R4 unchanged
    '{1'b0, 12'h0E0, 32'hDEAD_BEEF},  // R12 ch3 word0
    '{1'b0, 12'h0FC, 32'h1234_5678},  // R12 ch3 word7
    '{1'b0, 12'h7E0, 32'hA5A5_A5A5},  // R12 ch31 word0
    '{1'b1, 12'h0E0, 32'hDEAD_BEEF},  // R12
    '{1'b1, 12'h0FC, 32'h1234_5678},  // R12
    '{1'b1, 12'h7E0, 32'hA5A5_A5A5},  // R12
    '{1'b0, 12'h0C0, 32'h0},          // R5 release
    '{1'b1, 12'h0D0, 32'h10},         // R5 idle again
    '{1'b1, 12'h0C0, 32'h0},          // R5 source cleared
    '{1'b0, 12'hA00, 32'h0},          // R2 relock
    '{1'b1, 12'hA00, 32'h1},          // R2
    '{1'b0, 12'h0E0, 32'h0},          // R3 word write while locked
    '{1'b1, 12'h0E0, 32'hDEAD_BEEF}   // R3 word kept
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_rd) rd_chk($sformatf("vector %0d", i), VECS[i].addr, VECS[i].data);
      else wr(VECS[i].addr, VECS[i].data);
    end

    // automatic acknowledge path on channel 3, sender bit 4
    wr(12'hA00, 32'h1ACC_E551);
    wr(C3 + 12'h00, 32'h10);
    wr(C3 + 12'h04, 32'h3);
    wr(C3 + 12'h14, 32'hFFFF_FFFE);
    wr(C3 + 12'h10, 32'h1);
    rd_chk("R9 auto bit with ready", C3 + 12'h10, 32'h21);
    wr(C3 + 12'h1C, 32'h20);
    rd_chk("R6 wrong sender bit ignored", C3 + 12'h10, 32'h21);
    rd_chk("R6 nothing pending", C3 + 12'h0C, 32'h0);

    bus_addr = C3 + 12'h1C; bus_wdata = 32'h10; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    n = 1;
    check("R7 unmasked line high", {31'b0, irq_o[0]}, 32'h1);
    check("R7 masked line low", {31'b0, irq_o[1]}, 32'h0);
    while (!irq_o[4] && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R9 ack irq delay", 32'(n), 32'(D + 1));
    rd_chk("R9 ack state", C3 + 12'h10, 32'h81);
    rd_chk("R7 status masked", C3 + 12'h0C, 32'h1);
    wr(C3 + 12'h08, 32'h1);
    rd_chk("R8 status cleared", C3 + 12'h0C, 32'h0);
    check("R8 line dropped", {31'b0, irq_o[0]}, 32'h0);
    wr(C3 + 12'h18, 32'h10);
    rd_chk("R11 back to ready", C3 + 12'h10, 32'h21);
    check("R11 ack irq dropped", {31'b0, irq_o[4]}, 32'h0);

    // manual acknowledge path
    wr(C3 + 12'h10, 32'h0);
    wr(C3 + 12'h1C, 32'h10);
    rd_chk("R10 busy", C3 + 12'h10, 32'h40);
    repeat (2 * D) @(negedge clk);
    rd_chk("R10 no timed ack", C3 + 12'h10, 32'h40);
    wr(C3 + 12'h08, 32'h1);
    rd_chk("R10 still busy", C3 + 12'h10, 32'h40);
    wr(C3 + 12'h08, 32'h2);
    @(negedge clk);
    rd_chk("R10 ack after last clear", C3 + 12'h10, 32'h80);
    check("R10 ack irq", {31'b0, irq_o[4]}, 32'h1);

    // reset in the middle of activity
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd_chk("R1 relocked", 12'hA00, 32'h1);
    rd_chk("R1 idle", C3 + 12'h10, 32'h10);
    rd_chk("R1 mask", C3 + 12'h14, 32'hFFFF_FFFF);
    rd_chk("R1 source", C3 + 12'h00, 32'h0);
    check("R1 irq low", irq_o, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule